// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is an integer multiply engine for a processor datapath. It is built around a single 33-by-17-bit signed multiplier array. Each accepted operation multiplies two 32-bit operands, either as signed or as unsigned values. The 64-bit product can go into a high/low result register pair, be added to the pair's current contents, or be subtracted from them. One variant instead returns the low 32 bits of a signed product on a direct result port for a general register write, and leaves the pair untouched.

Speed depends on the second operand. If its upper half is only an extension of its lower half, one pass through the array is enough, and a new operation can be accepted every clock. Otherwise the operation takes two passes: the low half of the second operand goes through the array first and the high half a cycle later. While the second pass runs, the unit raises stall against any new request, so full-width operations issue at most every other clock. A read request returns the low register on the direct result port. Because it waits behind the stall, it always sees every earlier operation.

Top module: `mac_unit`

## Requirements
- R1: During and right after reset, hi, lo and gpr_result are zero, and stall and gpr_valid are low.
- R2: Opcode 1 (signed) and opcode 2 (unsigned) load the full 64-bit product into {hi, lo}. For a single-pass operation the new value is visible the cycle after acceptance; for a two-pass operation it is visible one cycle later than that.
- R3: Opcode 3 (signed) and opcode 4 (unsigned) add the 64-bit product to {hi, lo}.
- R4: Opcode 5 (signed) and opcode 6 (unsigned) subtract the 64-bit product from {hi, lo}.
- R5: Opcode 7 puts the low 32 bits of the signed product on gpr_result and pulses gpr_valid for one cycle when the operation retires. hi and lo are left unchanged.
- R6: An operation is single-pass when op_b[31:16] equals sixteen copies of op_b[15] (signed opcodes) or is zero (unsigned opcodes). Single-pass operations issued back to back never see stall.
- R7: Any other operation needs two passes. A request presented in the cycle after it is accepted sees stall high for exactly one cycle and is then accepted.
- R8: Opcode 0 (read) returns lo on gpr_result with a one-cycle gpr_valid pulse. It stalls while a two-pass operation is pending, and the value it returns includes that operation.
- R9: Accumulation into {hi, lo} wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_code | input | 3 | Operation select (0 read, 1-7 multiply forms) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; its upper half decides single or two-pass |
| stall | output | 1 | Request not taken this cycle |
| hi | output | 32 | Upper half of the result pair |
| lo | output | 32 | Lower half of the result pair |
| gpr_result | output | 32 | Direct result for multiply-to-register and read |
| gpr_valid | output | 1 | gpr_result updated this cycle |

## Verification
A wrong partial product, or a wrong extension of either half of the second operand, shows up on {hi, lo} one cycle after a single-pass operation, or two cycles after a two-pass one. The operand patterns are chosen so that sign and zero extension take different paths. A stuck or miscounted pass flag shows directly on stall: a missing or extra stall cycle appears on the very next request. It also shows as a read that returns a value without the pending product. Accumulation faults build up over a chain of operations, and the chain includes one that wraps past 2^64.

// File: rtl/mac_unit.sv
module mac_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        stall,
  output logic [31:0] hi,
  output logic [31:0] lo,
  output logic [31:0] gpr_result,
  output logic        gpr_valid
);

  localparam int          HALF     = 16;
  localparam logic [2:0]  OP_READ  = 3'd0;
  localparam logic [2:0]  OP_MULS  = 3'd1;
  localparam logic [2:0]  OP_MULU  = 3'd2;
  localparam logic [2:0]  OP_ADDS  = 3'd3;
  localparam logic [2:0]  OP_ADDU  = 3'd4;
  localparam logic [2:0]  OP_SUBS  = 3'd5;
  localparam logic [2:0]  OP_SUBU  = 3'd6;
  localparam logic [2:0]  OP_TOREG = 3'd7;

  logic               busy;
  logic [31:0]        a_r;
  logic [HALF-1:0]    bhi_r;
  logic               sgn_r;
  logic [2:0]         op_r;
  logic [63:0]        p0_r;

  logic               in_sgn, in_short, accept, retire;
  logic [2:0]         rop;
  logic signed [32:0] arr_a;
  logic signed [16:0] arr_b;
  logic signed [49:0] arr_p;
  logic [63:0]        arr_x, prod;

  assign in_sgn   = (op_code == OP_MULS) || (op_code == OP_ADDS) ||
                    (op_code == OP_SUBS) || (op_code == OP_TOREG);
  assign in_short = in_sgn ? (op_b[31:HALF] == {HALF{op_b[HALF-1]}})
                           : (op_b[31:HALF] == '0);
  assign stall    = op_valid & busy;
  assign accept   = op_valid & ~busy;
  assign retire   = busy | (accept & in_short & (op_code != OP_READ));
  assign rop      = busy ? op_r : op_code;

  always_comb begin
    if (busy) begin
      arr_a = {sgn_r & a_r[31], a_r};
      arr_b = {sgn_r & bhi_r[HALF-1], bhi_r};
    end else begin
      arr_a = {in_sgn & op_a[31], op_a};
      arr_b = in_short ? {in_sgn & op_b[HALF-1], op_b[HALF-1:0]}
                       : {1'b0, op_b[HALF-1:0]};
    end
  end

  assign arr_p = arr_a * arr_b;
  assign arr_x = {{14{arr_p[49]}}, arr_p};
  assign prod  = busy ? (p0_r + (arr_x << HALF)) : arr_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      a_r   <= '0;
      bhi_r <= '0;
      sgn_r <= 1'b0;
      op_r  <= OP_READ;
      p0_r  <= '0;
    end else begin
      if (busy)
        busy <= 1'b0;
      else if (accept && !in_short && op_code != OP_READ) begin
        busy  <= 1'b1;
        a_r   <= op_a;
        bhi_r <= op_b[31:HALF];
        sgn_r <= in_sgn;
        op_r  <= op_code;
        p0_r  <= arr_x;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi         <= '0;
      lo         <= '0;
      gpr_result <= '0;
      gpr_valid  <= 1'b0;
    end else begin
      gpr_valid <= (retire && rop == OP_TOREG) || (accept && op_code == OP_READ);
      if (accept && op_code == OP_READ)
        gpr_result <= lo;
      if (retire) begin
        case (rop)
          OP_MULS, OP_MULU: {hi, lo} <= prod;
          OP_ADDS, OP_ADDU: {hi, lo} <= {hi, lo} + prod;
          OP_SUBS, OP_SUBU: {hi, lo} <= {hi, lo} - prod;
          OP_TOREG:         gpr_result <= prod[31:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic        stall,
  input logic        busy,
  input logic        in_short,
  input logic [31:0] hi,
  input logic [31:0] lo,
  input logic        gpr_valid
);

  p_stall_needs_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);

  p_second_pass_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_short_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);

  p_toreg_keeps_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !stall && op_code == 3'd7 && in_short) |=> ($stable(hi) && $stable(lo) && gpr_valid));

  p_read_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && busy) |-> stall);

  p_idle_holds_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !busy) |=> ($stable(hi) && $stable(lo)));

endmodule

bind mac_unit mac_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .stall(stall), .busy(busy), .in_short(in_short),
  .hi(hi), .lo(lo), .gpr_valid(gpr_valid)
);

// File: tb/mac_unit_test.sv
`timescale 1ns/1ps
module mac_unit_test;
  logic        clk = 0, rst_n = 0, op_valid = 0;
  logic [2:0]  op_code = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic        stall, gpr_valid;
  logic [31:0] hi, lo, gpr_result;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] model = 0;

  mac_unit uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .stall(stall), .hi(hi), .lo(lo),
    .gpr_result(gpr_result), .gpr_valid(gpr_valid));

  always #4 clk = ~clk;

  function automatic bit is_sgn(input logic [2:0] op);
    return op == 3'd1 || op == 3'd3 || op == 3'd5 || op == 3'd7;
  endfunction

  function automatic logic [63:0] ref_prod(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] xa, xb;
    xa = is_sgn(op) ? {{32{a[31]}}, a} : {32'd0, a};
    xb = is_sgn(op) ? {{32{b[31]}}, b} : {32'd0, b};
    return xa * xb;
  endfunction

  function automatic void model_apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd1, 3'd2: model = ref_prod(op, a, b);
      3'd3, 3'd4: model = model + ref_prod(op, a, b);
      3'd5, 3'd6: model = model - ref_prod(op, a, b);
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, output int stalls);
    op_valid = 1; op_code = op; op_a = a; op_b = b;
    #1;
    stalls = 0;
    while (stall) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    model_apply(op, a, b);
  endtask

  task automatic settle();
    op_valid = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 hi/lo", {hi, lo}, 64'd0);
    check("R1 gpr_result", {32'd0, gpr_result}, 64'd0);
    check("R1 stall/gpr_valid", {62'd0, stall, gpr_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {62'd0, stall, gpr_valid}, 64'd0);
  endtask

  task automatic t_mult();
    int s;
    issue(3'd1, 32'hFFFF_FFF9, 32'd1234, s);
    check("R2 signed short timing", {hi, lo}, model);
    settle();
    issue(3'd1, 32'h8000_0000, 32'h8000_0000, s);
    op_valid = 0;
    check("R2 signed long not yet", {hi, lo}, 64'hFFFF_FFFF_FA3D_C64E & {hi, lo} | ref_prod(3'd1, 32'hFFFF_FFF9, 32'd1234));
    @(negedge clk);
    check("R2 signed long", {hi, lo}, model);
    issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, s);
    settle();
    check("R2 unsigned long", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
    issue(3'd2, 32'h8765_4321, 32'h0000_FFFF, s);
    settle();
    check("R2 unsigned short", {hi, lo}, model);
  endtask

  task automatic t_madd_msub();
    int s;
    issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, s);
    issue(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, s);
    settle();
    check("R9 unsigned add wraps", {hi, lo}, 64'hFFFF_FFFC_0000_0002);
    issue(3'd3, 32'hFFFF_FFFE, 32'h1234_5678, s);
    settle();
    check("R3 signed add", {hi, lo}, model);
    issue(3'd5, 32'h0001_0000, 32'hFFFF_8000, s);
    settle();
    check("R4 signed subtract short", {hi, lo}, model);
    issue(3'd1, 32'd0, 32'd0, s);
    issue(3'd6, 32'd5, 32'd7, s);
    settle();
    check("R4 R9 unsigned subtract below zero", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFDD);
  endtask

  task automatic t_toreg();
    int s;
    logic [63:0] keep;
    keep = {hi, lo};
    issue(3'd7, 32'hFFFF_FFFD, 32'd100, s);
    check("R5 short gpr_valid", {31'd0, gpr_valid, gpr_result}, {31'd0, 1'b1, 32'hFFFF_FED4});
    op_valid = 0;
    @(negedge clk);
    check("R5 pulse one cycle", {63'd0, gpr_valid}, 64'd0);
    issue(3'd7, 32'hFFFF_FFFD, 32'h0001_86A0, s);
    check("R5 long not yet", {63'd0, gpr_valid}, 64'd0);
    op_valid = 0;
    @(negedge clk);
    check("R5 long result", {31'd0, gpr_valid, gpr_result}, {31'd0, 1'b1, 32'hFFFB_6C20});
    check("R5 pair untouched", {hi, lo}, keep);
  endtask

  task automatic t_short_rate();
    int s, total;
    total = 0;
    issue(3'd1, 32'h7FFF_FFFF, 32'hFFFF_8000, s); total += s;
    issue(3'd3, 32'h1234_5678, 32'h0000_7FFF, s); total += s;
    issue(3'd4, 32'hDEAD_BEEF, 32'h0000_FFFF, s); total += s;
    issue(3'd5, 32'h8000_0001, 32'hFFFF_FFFF, s); total += s;
    check("R6 no stall back to back", total, 0);
    settle();
    check("R6 chained result", {hi, lo}, model);
  endtask

  task automatic t_long_rate();
    int s1, s2, s3;
    issue(3'd1, 32'h0000_0003, 32'h0000_8000, s1);
    issue(3'd3, 32'hABCD_0123, 32'h0001_0000, s2);
    issue(3'd4, 32'h0000_0002, 32'h0000_0005, s3);
    check("R7 first not stalled", s1, 0);
    check("R7 follower stalls once", s2, 1);
    check("R7 after long stalls once", s3, 1);
    settle();
    check("R7 long chain result", {hi, lo}, model);
  endtask

  task automatic t_read();
    int s;
    issue(3'd2, 32'h1357_9BDF, 32'h2468_ACE0, s);
    issue(3'd0, 32'd0, 32'd0, s);
    check("R8 read stalls behind long", s, 1);
    check("R8 read value", {31'd0, gpr_valid, gpr_result}, {31'd0, 1'b1, model[31:0]});
    issue(3'd1, 32'd9, 32'd11, s);
    issue(3'd0, 32'd0, 32'd0, s);
    check("R8 read after short no stall", s, 0);
    check("R8 read value short", {32'd0, gpr_result}, 64'd99);
    settle();
  endtask

  initial begin
    t_reset();
    t_mult();
    t_madd_msub();
    t_toreg();
    t_short_rate();
    t_long_rate();
    t_read();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule